// File: doc/BRIEF.md
# Clock mode and coprocessor reset controller

This block manages the clocks of two domains, a controller core and an audio coprocessor, from two 8-bit control registers written over a simple write port. From the configuration register it produces the PLL enable, the PLL output frequency select, the divide ratio for each domain and the low-speed oscillator enable. From the mode register it takes the request to run the core from the PLL instead of the 32.768 kHz clock. The analog PLL is not part of the block. Its lock time is modelled as a settle counter that advances on a slow-clock tick input. The core is moved onto the PLL only after that counter has run out. A request that arrives earlier is held and is applied on its own once the PLL is ready.

The coprocessor is held in reset until the reset bit of the configuration register has been written 1, then 0, then 1 over three consecutive configuration writes. Release opens a busy window of a parameterised number of core cycles. During that window, and while the coprocessor is held in reset, the command-valid input is not passed through to the command-accept output. While the coprocessor runs from an enabled PLL, the frequency and divider fields are frozen. A write that would change those fields, or a write that sets the reset bit while the PLL is still settling, raises a sticky error flag.

Top module: `clock_mode_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x26, the mode register reads 1, the PLL is off and not ready, the core is on the slow clock, the coprocessor is held in reset, busy and error are low.
- R2: The decoded outputs follow the configuration register. Bits 7:6 give the frequency select. Bit 5 gives the audio divide shift (0 = /1, 1 = /2). Bit 3 gives the PLL enable and bit 0 the low-speed oscillator enable. Bits 2:1 give the core divide shift: 01 gives 0 (/1), 10 gives 1 (/2), and both 11 and 00 give 2 (/4).
- R3: The PLL ready flag rises at the SETTLE_TICKS-th slow tick after a configuration write that turns the PLL on, or that changes bits 7:5 or 2:1 while the PLL stays on. Such a write restarts the count. Turning the PLL off clears ready at once.
- R4: The core runs from the PLL exactly when the mode register (address 0, bit 0) holds 0 and the PLL is ready. A 0 written before ready is kept pending and takes effect in the same cycle ready rises.
- R5: When ready is lost, the core returns to the slow clock at once. The mode register keeps its value, and the core goes back to the PLL when ready returns.
- R6: The coprocessor reset output falls only on a configuration write (address 1) whose applied bit 4 is 1 and whose two preceding configuration writes applied 1 and then 0 to bit 4. Other orders keep it in reset.
- R7: A configuration write that applies 0 to bit 4 puts the coprocessor back into reset on that edge and ends any busy window.
- R8: Busy is high for exactly BUSY_CYCLES cycles, starting with the cycle in which the reset output falls.
- R9: Command accept is high only when command valid is high, the coprocessor is out of reset and busy is low.
- R10: While the coprocessor is out of reset and the PLL is enabled, a configuration write keeps the previous values of bits 7:5 and 2:1. Its other bits still take effect. If the write tried to change a frozen bit, the error flag is set.
- R11: A configuration write that would set bit 4 from 0 while the applied PLL enable is 1 has bit 4 forced to 0 and sets the error flag, when the PLL is not ready or the same write restarts the settle count.
- R12: The error flag stays high once set and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period, advances the settle count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the mode register, 1 the configuration register |
| wr_data | input | 8 | Write data |
| cmd_valid | input | 1 | Command offered to the coprocessor |
| cfg_q | output | 8 | Applied configuration register |
| mode_q | output | 1 | Mode register, 1 = slow clock requested |
| pll_en | output | 1 | PLL enable |
| pll_freq_sel | output | 2 | PLL output frequency select |
| core_div_shift | output | 2 | Core divide as a power of two |
| audio_div_shift | output | 1 | Audio divide as a power of two |
| lxt_en | output | 1 | Low-speed oscillator enable |
| pll_ready | output | 1 | PLL settle time elapsed |
| core_on_pll | output | 1 | Core clock taken from the PLL |
| cop_rst | output | 1 | Coprocessor reset, active high |
| cop_busy | output | 1 | Coprocessor initialisation window open |
| cmd_accept | output | 1 | Command passed to the coprocessor |
| cfg_err | output | 1 | Sticky rule-violation flag |

## Verification
The reset-bit sequence is driven with the patterns 1-1, 0-0-1, 0-1-1 and 1-0-1. This separates a true history match from a detector that fires on any rising bit or on the last two writes alone. The PLL request is made both before the PLL is enabled and while it is settling, and the settle count is restarted by a frequency change. This shows whether the pending switch lands on the exact cycle ready rises and falls back when ready is lost. Frozen-field writes are mixed with writes that only touch unfrozen bits, so that partial application and error raising are seen separately. A busy window is also cut short by a reset-bit clear.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int unsigned REG_W = 8;

  // configuration register bit positions (decoded by neighbours)
  localparam int unsigned B_FSEL_LO = 6;
  localparam int unsigned B_ADIV    = 5;
  localparam int unsigned B_CRST    = 4;
  localparam int unsigned B_PLLEN   = 3;
  localparam int unsigned B_CDIV_LO = 1;
  localparam int unsigned B_LXT     = 0;

  localparam logic [REG_W-1:0] CFG_POR    = 8'h26;
  localparam logic             MODE_POR   = 1'b1;
  // frequency select and divider fields, frozen while the coprocessor runs
  localparam logic [REG_W-1:0] RATIO_MASK = 8'hE6;

  typedef enum logic {
    ADDR_MODE = 1'b0,
    ADDR_CFG  = 1'b1
  } reg_addr_e;

  function automatic logic [1:0] core_shift(input logic [1:0] fld);
    case (fld)
      2'b01:   core_shift = 2'd0;
      2'b10:   core_shift = 2'd1;
      default: core_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/cmc_cfg_reg.sv
module cmc_cfg_reg
  import cmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             locked,
  input  logic             ready,
  output logic [REG_W-1:0] cfg_q,
  output logic             pll_en_d,
  output logic             crst_d,
  output logic             restart,
  output logic             err_q
);
  logic [REG_W-1:0] masked;
  logic [REG_W-1:0] cfg_d;
  logic             lock_hit;
  logic             crst_reject;

  always_comb begin
    masked      = locked ? ((wdata & ~RATIO_MASK) | (cfg_q & RATIO_MASK)) : wdata;
    lock_hit    = wr && locked && (((wdata ^ cfg_q) & RATIO_MASK) != '0);
    restart     = wr && masked[B_PLLEN] &&
                  (!cfg_q[B_PLLEN] || (((masked ^ cfg_q) & RATIO_MASK) != '0));
    crst_reject = wr && masked[B_CRST] && !cfg_q[B_CRST] && masked[B_PLLEN] &&
                  (restart || !ready);
    cfg_d = cfg_q;
    if (wr) begin
      cfg_d = masked;
      if (crst_reject) cfg_d[B_CRST] = 1'b0;
    end
    pll_en_d = cfg_d[B_PLLEN];
    crst_d   = cfg_d[B_CRST];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_POR;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_q | lock_hit | crst_reject;
    end
  end
endmodule

// File: rtl/cmc_pll_guard.sv
module cmc_pll_guard
  import cmc_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 328
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick,
  input  logic pll_en_d,
  input  logic restart,
  input  logic mode_wr,
  input  logic mode_bit,
  output logic ready_q,
  output logic core_pll_q,
  output logic mode_q
);
  localparam int unsigned SW = $clog2(SETTLE_TICKS + 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          ready_d;
  logic          mode_d;

  always_comb begin
    cnt_d   = cnt_q;
    ready_d = ready_q;
    mode_d  = mode_wr ? mode_bit : mode_q;
    if (!pll_en_d) begin
      cnt_d   = '0;
      ready_d = 1'b0;
    end else if (restart) begin
      cnt_d   = SW'(SETTLE_TICKS);
      ready_d = 1'b0;
    end else if (slow_tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == SW'(1)) ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      ready_q    <= 1'b0;
      mode_q     <= MODE_POR;
      core_pll_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      ready_q    <= ready_d;
      mode_q     <= mode_d;
      core_pll_q <= !mode_d && ready_d;
    end
  end
endmodule

// File: rtl/cmc_cop_seq.sv
module cmc_cop_seq #(
  parameter int unsigned BUSY_CYCLES = 1638400
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic bit_d,
  output logic run_q,
  output logic busy_q
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

  logic [1:0]    hist_q;
  logic [CW-1:0] cnt_q;
  logic          release_now;

  assign release_now = wr && bit_d && (hist_q == 2'b10);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 2'b00;
      run_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr) hist_q <= {hist_q[0], bit_d};
      if (release_now) begin
        run_q  <= 1'b1;
        busy_q <= 1'b1;
        cnt_q  <= LOAD;
      end else if (wr && !bit_d) begin
        run_q  <= 1'b0;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/clock_mode_ctrl.sv
module clock_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 328,
  parameter int unsigned BUSY_CYCLES  = 1638400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_tick,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       cmd_valid,
  output logic [7:0] cfg_q,
  output logic       mode_q,
  output logic       pll_en,
  output logic [1:0] pll_freq_sel,
  output logic [1:0] core_div_shift,
  output logic       audio_div_shift,
  output logic       lxt_en,
  output logic       pll_ready,
  output logic       core_on_pll,
  output logic       cop_rst,
  output logic       cop_busy,
  output logic       cmd_accept,
  output logic       cfg_err
);
  logic cfg_wr, mode_wr;
  logic pll_en_d, crst_d, restart;
  logic run_q, locked;

  assign cfg_wr  = wr_en && (wr_addr == ADDR_CFG);
  assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
  assign locked  = run_q && cfg_q[B_PLLEN];

  cmc_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .wdata    (wr_data),
    .locked   (locked),
    .ready    (pll_ready),
    .cfg_q    (cfg_q),
    .pll_en_d (pll_en_d),
    .crst_d   (crst_d),
    .restart  (restart),
    .err_q    (cfg_err)
  );

  cmc_pll_guard #(.SETTLE_TICKS(SETTLE_TICKS)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .slow_tick  (slow_tick),
    .pll_en_d   (pll_en_d),
    .restart    (restart),
    .mode_wr    (mode_wr),
    .mode_bit   (wr_data[0]),
    .ready_q    (pll_ready),
    .core_pll_q (core_on_pll),
    .mode_q     (mode_q)
  );

  cmc_cop_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .wr     (cfg_wr),
    .bit_d  (crst_d),
    .run_q  (run_q),
    .busy_q (cop_busy)
  );

  assign pll_en          = cfg_q[B_PLLEN];
  assign pll_freq_sel    = cfg_q[B_FSEL_LO +: 2];
  assign core_div_shift  = core_shift(cfg_q[B_CDIV_LO +: 2]);
  assign audio_div_shift = cfg_q[B_ADIV];
  assign lxt_en          = cfg_q[B_LXT];
  assign cop_rst         = !run_q;
  assign cmd_accept      = cmd_valid && run_q && !cop_busy;
endmodule

// File: rtl/cmc_chk.sv
module cmc_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic       mode_q,
  input logic       pll_en,
  input logic [1:0] pll_freq_sel,
  input logic [1:0] core_div_shift,
  input logic       audio_div_shift,
  input logic       pll_ready,
  input logic       core_on_pll,
  input logic       cop_rst,
  input logic       cop_busy,
  input logic       cfg_err
);
  a_r3_ready_needs_en: assert property (@(posedge clk) disable iff (rst)
    pll_ready |-> pll_en);

  a_r4_pll_needs_ready: assert property (@(posedge clk) disable iff (rst)
    core_on_pll |-> pll_ready);

  a_r4_pending_applied: assert property (@(posedge clk) disable iff (rst)
    (pll_ready && !mode_q) |-> core_on_pll);

  a_r6_release_on_write: assert property (@(posedge clk) disable iff (rst)
    $fell(cop_rst) |-> $past(wr_en && wr_addr && wr_data[4]));

  a_r8_busy_only_running: assert property (@(posedge clk) disable iff (rst)
    cop_busy |-> !cop_rst);

  a_r8_busy_starts_at_release: assert property (@(posedge clk) disable iff (rst)
    $rose(cop_busy) |-> $fell(cop_rst));

  a_r10_fields_frozen: assert property (@(posedge clk) disable iff (rst)
    (!cop_rst && pll_en) |=> ($stable(pll_freq_sel) && $stable(core_div_shift) &&
                              $stable(audio_div_shift)));

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

bind clock_mode_ctrl cmc_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .wr_en           (wr_en),
  .wr_addr         (wr_addr),
  .wr_data         (wr_data),
  .mode_q          (mode_q),
  .pll_en          (pll_en),
  .pll_freq_sel    (pll_freq_sel),
  .core_div_shift  (core_div_shift),
  .audio_div_shift (audio_div_shift),
  .pll_ready       (pll_ready),
  .core_on_pll     (core_on_pll),
  .cop_rst         (cop_rst),
  .cop_busy        (cop_busy),
  .cfg_err         (cfg_err)
);

// File: tb/clock_mode_ctrl_tb.sv
module clock_mode_ctrl_tb;
  localparam int SETTLE = 5;
  localparam int BUSY   = 12;
  localparam int TP     = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_valid = 1'b0;
  logic [7:0] cfg_q;
  logic       mode_q, pll_en, audio_div_shift, lxt_en, pll_ready, core_on_pll;
  logic       cop_rst, cop_busy, cmd_accept, cfg_err;
  logic [1:0] pll_freq_sel, core_div_shift;

  int n_chk = 0;
  int n_fail = 0;

  clock_mode_ctrl #(.SETTLE_TICKS(SETTLE), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cfg_q(cfg_q), .mode_q(mode_q),
    .pll_en(pll_en), .pll_freq_sel(pll_freq_sel), .core_div_shift(core_div_shift),
    .audio_div_shift(audio_div_shift), .lxt_en(lxt_en), .pll_ready(pll_ready),
    .core_on_pll(core_on_pll), .cop_rst(cop_rst), .cop_busy(cop_busy),
    .cmd_accept(cmd_accept), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // slow-clock strobe, one cycle in TP
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt++;
    slow_tick <= (tcnt % TP == 0);
  end

  // behavioural reference model
  bit [7:0] m_cfg;
  bit [1:0] m_hist;
  bit       m_mode, m_ready, m_core, m_run, m_err;
  int       m_cnt, m_busy;

  always @(posedge clk) begin : model
    bit [7:0] nv;
    bit rs, rel;
    if (rst) begin
      m_cfg = 8'h26; m_hist = 2'b00; m_mode = 1; m_ready = 0; m_core = 0;
      m_run = 0; m_err = 0; m_cnt = 0; m_busy = 0;
    end else begin
      nv = m_cfg; rs = 0; rel = 0;
      if (wr_en && wr_addr) begin
        nv = wr_data;
        if (m_run && m_cfg[3]) begin
          for (int b = 0; b < 8; b++)
            if ((b == 7 || b == 6 || b == 5 || b == 2 || b == 1) && nv[b] != m_cfg[b]) begin
              nv[b] = m_cfg[b];
              m_err = 1;
            end
        end
        rs = nv[3] && (!m_cfg[3] || nv[7:5] != m_cfg[7:5] || nv[2:1] != m_cfg[2:1]);
        if (nv[4] && !m_cfg[4] && nv[3] && (rs || !m_ready)) begin
          nv[4] = 0;
          m_err = 1;
        end
        rel = nv[4] && (m_hist == 2'b10);
        m_hist = {m_hist[0], nv[4]};
        if (rel) begin m_run = 1; m_busy = BUSY; end
        else if (!nv[4]) begin m_run = 0; m_busy = 0; end
        else if (m_busy > 0) m_busy--;
      end else if (m_busy > 0) m_busy--;
      m_cfg = nv;
      if (!m_cfg[3]) begin m_cnt = 0; m_ready = 0; end
      else if (rs) begin m_cnt = SETTLE; m_ready = 0; end
      else if (slow_tick && m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_ready = 1;
      end
      if (wr_en && !wr_addr) m_mode = wr_data[0];
      m_core = !m_mode && m_ready;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int cs;
      cs = (m_cfg[2:1] == 2'b01) ? 0 : (m_cfg[2:1] == 2'b10) ? 1 : 2;
      chk("R10 cfg", cfg_q, m_cfg);
      chk("R2 fsel", pll_freq_sel, m_cfg[7:6]);
      chk("R2 cdiv", core_div_shift, cs);
      chk("R2 adiv", audio_div_shift, m_cfg[5]);
      chk("R2 lxt", lxt_en, m_cfg[0]);
      chk("R3 ready", pll_ready, m_ready);
      chk("R4 mode", mode_q, m_mode);
      chk("R4 core_on_pll", core_on_pll, m_core);
      chk("R6 cop_rst", cop_rst, !m_run);
      chk("R8 busy", cop_busy, m_busy > 0);
      chk("R9 accept", cmd_accept, cmd_valid && m_run && m_busy == 0);
      chk("R12 err", cfg_err, m_err);
    end
  end

  task automatic wr(input bit a, input bit [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    idle(2);
    rst = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfg_q, 8'h26);
    chk("R1 mode", mode_q, 1);
    chk("R1 pll", pll_en, 0);
    chk("R1 ready", pll_ready, 0);
    chk("R1 core", core_on_pll, 0);
    chk("R1 rst", cop_rst, 1);
    chk("R1 busy", cop_busy, 0);
    chk("R1 err", cfg_err, 0);

    // R2 field decodes
    wr(1, 8'h42); chk("R2 fsel 01", pll_freq_sel, 1); chk("R2 cdiv 01", core_div_shift, 0);
    wr(1, 8'hA4); chk("R2 fsel 10", pll_freq_sel, 2); chk("R2 cdiv 10", core_div_shift, 1);
    chk("R2 adiv", audio_div_shift, 1);
    wr(1, 8'hC1); chk("R2 cdiv 00", core_div_shift, 2); chk("R2 lxt", lxt_en, 1);

    // R4 request with PLL off stays pending
    wr(0, 8'h00); chk("R4 pending", core_on_pll, 0); chk("R4 mode", mode_q, 0);

    // R3 settle window
    wr(1, 8'hC8); chk("R3 not ready", pll_ready, 0);
    n = 0;
    while (!pll_ready && n < 100) begin @(negedge clk); n++; end
    chk("R3 window lo", n >= (SETTLE - 1) * TP, 1);
    chk("R3 window hi", n <= SETTLE * TP, 1);
    chk("R4 applied", core_on_pll, 1);

    // R5 restart by frequency change
    wr(1, 8'h48); chk("R5 fallback", core_on_pll, 0); chk("R5 mode kept", mode_q, 0);
    idle(SETTLE * TP + 2); chk("R5 return", core_on_pll, 1);

    // R11 reset bit during restart rejected
    wr(1, 8'h98); chk("R11 bit kept 0", cfg_q[4], 0); chk("R11 err", cfg_err, 1);
    wr(1, 8'h08); chk("R12 err sticky", cfg_err, 1);
    do_reset(); chk("R12 err cleared", cfg_err, 0);

    // R6 patterns that must not release
    cmd_valid = 1;
    wr(1, 8'h10); wr(1, 8'h10); chk("R6 11", cop_rst, 1);
    wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h10); chk("R6 001", cop_rst, 1);
    wr(1, 8'h10); chk("R6 011", cop_rst, 1); chk("R9 in reset", cmd_accept, 0);
    wr(1, 8'h00); wr(1, 8'h10); chk("R6 101", cop_rst, 0);
    // R8 busy length
    n = 0;
    while (cop_busy && n < 100) begin n++; @(negedge clk); end
    chk("R8 busy length", n, BUSY);
    chk("R9 accepted", cmd_accept, 1);
    cmd_valid = 0; @(negedge clk); chk("R9 no valid", cmd_accept, 0);

    // R10 freeze while running from PLL
    wr(1, 8'h1A); idle(SETTLE * TP + 2); chk("R10 ready", pll_ready, 1);
    wr(1, 8'h1B); chk("R10 free bit", cfg_q, 8'h1B); chk("R10 no err", cfg_err, 0);
    wr(1, 8'h5C); chk("R10 frozen", cfg_q, 8'h1A); chk("R10 err", cfg_err, 1);

    // R7 clear ends busy
    wr(1, 8'h0A); chk("R7 back in reset", cop_rst, 1);
    wr(1, 8'h1A); chk("R6 re-release", cop_rst, 0); chk("R8 busy on", cop_busy, 1);
    idle(3);
    wr(1, 8'h0A); chk("R7 busy cut", cop_busy, 0); chk("R7 reset", cop_rst, 1);

    // R4 slow request takes effect at once
    wr(0, 8'h00); idle(1);
    wr(0, 8'h01); chk("R4 slow", core_on_pll, 0);
    idle(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule